// File: doc/BRIEF.md
# Three-Channel Timer Port Interface

This block is the byte-wide register front end of a three-channel interval timer. A host issues single-byte port accesses (address, valid strobe, write flag, write byte). The block decodes the address, steers the byte to one of three 16-bit down-counter channels or to the control and speaker ports, and returns a registered read byte together with a registered "handled" flag one cycle later. Only exact matches on the configured port numbers are claimed.

The control port programs a channel's access width and counting mode. It also carries two latch forms. The first is a single-channel count latch. The second is a multi-channel read-back command that picks channels through a bitmask. A speaker port drives the gate of channel 2 and reports that channel's output. The channels advance on a shared `tick` enable. Events from channel 0 become a one-cycle interrupt pulse and advance a saturating event total. Events from channels 1 and 2 raise no interrupt.

Top module: `tmr_port_if`

## Requirements
- R1: A valid access to 0x40, 0x41, 0x42 (data ports of channels 0, 1, 2), 0x43 (control) or 0x61 (speaker) sets `io_handled` in the following cycle. Any other 16-bit address leaves `io_handled` low and `io_rdata` at 0x00.
- R2: Control word layout: bits 7:6 give the channel (3 means read-back), bits 5:4 the access width (0 latch, 1 low byte only, 2 high byte only, 3 low byte then high byte), and bits 3:1 the counting mode. Mode codes 6 and 7 behave as mode 0. Bit 0 is accepted, and counting is always binary.
- R3: A control word with a nonzero access field stores the access width and the mode. It returns both byte-order toggles to the low byte and stops the channel, whose count holds, until a new count is loaded. The tick of that same cycle is dropped.
- R4: A data write loads the count in these ways. Access 1 loads the byte. Access 2 loads the byte shifted up by 8. Access 3 loads on the second (high) byte. A loaded value of 0 becomes 0xFFFF. The sequence 0x34 to 0x43, then 0x00 and 0x04 to 0x40, gives channel 0 mode 2 with a reload of 0x0400.
- R5: A data read returns the low byte for access 0 and 1 and the high byte for access 2. For access 3, successive reads return the low byte, then the high byte.
- R6: A control word with access 0 freezes that channel's count into a latch and changes nothing else. Reads return the frozen value until the read sequence completes: one read, or two reads for access 3. A latch request while a frozen value is still pending is ignored.
- R7: A read-back word (bits 7:6 = 3) applies a count latch to each channel whose select bit is set. Bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2. The latch is applied when bit 5 is clear or bit 4 is clear. With both bits 5 and 4 set, nothing is latched.
- R8: Counting on each tick while enabled and gated works as follows. Mode 2 decrements, reloads after reaching 0 and emits an event every reload+1 ticks. Mode 0 drives the output low at load, then emits a single event, raises the output and stops on the tick after the count reaches 0. Mode 3 reloads the same way, toggles the output at each reload and emits an event on each rising output.
- R9: A speaker-port write sets the speaker gate, which is also the gate of channel 2, from bit 0. A speaker-port read returns the gate in bit 0 and the channel 2 output in bit 5, with all other bits 0. After reset, channels 0 and 1 are gated on, channel 2 is gated off, and every output is high.
- R10: A read of the control port returns 0xFF.
- R11: Each channel-0 event produces a one-cycle `irq` pulse in the next cycle. Events of channels 1 and 2 produce neither a pulse nor a count.
- R12: `irq_count` increments on each channel-0 event and holds at its all-ones value instead of wrapping.
- R13: A count load or a configuring control word takes priority over a tick in the same cycle, and that tick is dropped. A data read in a tick cycle returns the value from before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable shared by all channels |
| io_valid | input | 1 | Port access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W (16) | Port address |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte, valid the cycle after a read |
| io_handled | output | 1 | Registered flag: the previous access hit a known port |
| irq | output | 1 | One-cycle pulse per channel-0 event |
| irq_count | output | IRQ_CNT_W (8) | Saturating total of channel-0 events |

## Verification
The functions that collide are the tick-driven counting and the port accesses. A tick can land in the same cycle as a count load, a configuring control word, a data read or a latch. The bench raises `tick` together with the access strobe. It then reads the channel back through its data port with counting stopped. A dropped tick must leave exactly the loaded value, and a read in a tick cycle must return the pre-tick count, followed by a value one lower on the next read. Latches taken while ticks keep running are judged against counts computed from the number of ticks driven.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned NUM_CH = 3;
   localparam int unsigned CNT_W  = 16;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      MODE_TERM      = 3'd0,
      MODE_ONE_SHOT  = 3'd1,
      MODE_RATE      = 3'd2,
      MODE_SQUARE    = 3'd3,
      MODE_SW_STROBE = 3'd4,
      MODE_HW_STROBE = 3'd5
   } tmr_mode_e;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_LOHI  = 2'd3
   } tmr_acc_e;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
   import tmr_pkg::*;
(
   input  logic              ctrl_wr,
   input  logic [BYTE_W-1:0] cw,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] latch_req,
   output tmr_acc_e          cfg_acc,
   output logic [2:0]        cfg_mode
);
   localparam logic [1:0] READBACK_SEL = 2'd3;

   logic [1:0] ch_field;
   logic       is_readback;
   logic       rb_wants_latch;

   assign ch_field       = cw[7:6];
   assign cfg_acc        = tmr_acc_e'(cw[5:4]);
   assign cfg_mode       = cw[3:1];
   assign is_readback    = ctrl_wr && (ch_field == READBACK_SEL);
   assign rb_wants_latch = !cw[5] || !cw[4];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      logic addressed;
      assign addressed    = ctrl_wr && (ch_field == 2'(i));
      assign cfg_we[i]    = addressed && (cfg_acc != ACC_LATCH);
      assign latch_req[i] = (addressed && (cfg_acc == ACC_LATCH)) ||
                            (is_readback && rb_wants_latch && cw[i+1]);
   end
endmodule

// File: rtl/tmr_chan_ctr.sv
module tmr_chan_ctr
   import tmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate,
   input  logic              cfg_we,
   input  tmr_acc_e          cfg_acc,
   input  logic [2:0]        cfg_mode,
   input  logic              latch_req,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              out,
   output logic              evt
);
   localparam logic [2:0] LAST_MODE = 3'd5;

   logic [CNT_W-1:0] count, n_count, reload, n_reload, lval, n_lval;
   logic [CNT_W-1:0] ld_val, ld_eff, shown;
   tmr_mode_e        mode, n_mode;
   tmr_acc_e         acc, n_acc;
   logic             en, n_en, n_out, lvld, n_lvld, rd_lo, n_rd_lo;
   logic             wr_lo, n_wr_lo, ld;

   assign shown  = lvld ? lval : count;
   assign ld_eff = (ld_val == '0) ? '1 : ld_val;

   always_comb begin
      case (acc)
         ACC_HI:   rd_byte = shown[15:8];
         ACC_LOHI: rd_byte = rd_lo ? shown[7:0] : shown[15:8];
         default:  rd_byte = shown[7:0];
      endcase
   end

   always_comb begin
      n_count = count;  n_reload = reload; n_mode = mode;   n_acc   = acc;
      n_en    = en;     n_out    = out;    n_lval = lval;   n_lvld  = lvld;
      n_rd_lo = rd_lo;  n_wr_lo  = wr_lo;
      ld      = 1'b0;   ld_val   = '0;     evt    = 1'b0;
      if (cfg_we) begin
         n_acc   = cfg_acc;
         n_mode  = (cfg_mode > LAST_MODE) ? MODE_TERM : tmr_mode_e'(cfg_mode);
         n_wr_lo = 1'b1;
         n_rd_lo = 1'b1;
         n_en    = 1'b0;
      end else begin
         if (latch_req && !lvld) begin
            n_lval  = count;
            n_lvld  = 1'b1;
            n_rd_lo = 1'b1;
         end
         if (wr_en) begin
            case (acc)
               ACC_LO: begin ld = 1'b1; ld_val = {8'h00, wr_byte}; end
               ACC_HI: begin ld = 1'b1; ld_val = {wr_byte, 8'h00}; end
               ACC_LOHI: begin
                  if (wr_lo) begin
                     n_reload = {reload[15:8], wr_byte};
                     n_wr_lo  = 1'b0;
                  end else begin
                     ld      = 1'b1;
                     ld_val  = {wr_byte, reload[7:0]};
                     n_wr_lo = 1'b1;
                  end
               end
               default: ;
            endcase
         end
         if (rd_en) begin
            if (acc == ACC_LOHI) begin
               n_rd_lo = !rd_lo;
               if (!rd_lo) n_lvld = 1'b0;
            end else begin
               n_lvld = 1'b0;
            end
         end
         if (ld) begin
            n_reload = ld_eff;
            n_count  = ld_eff;
            n_en     = 1'b1;
            n_out    = (mode != MODE_TERM);
         end else if (tick && en && gate) begin
            if (count == '0) begin
               case (mode)
                  MODE_RATE: begin
                     n_count = reload;
                     evt     = 1'b1;
                  end
                  MODE_SQUARE: begin
                     n_count = reload;
                     n_out   = !out;
                     evt     = !out;
                  end
                  default: begin
                     n_out = 1'b1;
                     n_en  = 1'b0;
                     evt   = 1'b1;
                  end
               endcase
            end else begin
               n_count = count - CNT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;        reload <= '0;      lval  <= '0;
         mode  <= MODE_TERM; acc    <= ACC_LATCH;
         en    <= 1'b0;      out    <= 1'b1;    lvld  <= 1'b0;
         rd_lo <= 1'b1;      wr_lo  <= 1'b1;
      end else begin
         count <= n_count;   reload <= n_reload; lval  <= n_lval;
         mode  <= n_mode;    acc    <= n_acc;
         en    <= n_en;      out    <= n_out;    lvld  <= n_lvld;
         rd_lo <= n_rd_lo;   wr_lo  <= n_wr_lo;
      end
   end

   // R9
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !cfg_we && !wr_en) |=> $stable(count));

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvld && !rd_en) |=> (lvld && $stable(lval)));

   // R3
   cfg_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (!en && $stable(count)));
endmodule

// File: rtl/tmr_port_if.sv
module tmr_port_if
   import tmr_pkg::*;
#(
   parameter int unsigned   ADDR_W    = 16,
   parameter int unsigned   DATA_BASE = 16'h0040,
   parameter int unsigned   CTRL_PORT = 16'h0043,
   parameter int unsigned   SPKR_PORT = 16'h0061,
   parameter int unsigned   GATED_CH  = 2,
   parameter int unsigned   IRQ_CNT_W = 8
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 io_valid,
   input  logic                 io_write,
   input  logic [ADDR_W-1:0]    io_addr,
   input  logic [BYTE_W-1:0]    io_wdata,
   output logic [BYTE_W-1:0]    io_rdata,
   output logic                 io_handled,
   output logic                 irq,
   output logic [IRQ_CNT_W-1:0] irq_count
);
   localparam logic [ADDR_W-1:0]    BASE_A = ADDR_W'(DATA_BASE);
   localparam logic [ADDR_W-1:0]    CTRL_A = ADDR_W'(CTRL_PORT);
   localparam logic [ADDR_W-1:0]    SPKR_A = ADDR_W'(SPKR_PORT);
   localparam logic [IRQ_CNT_W-1:0] CNT_MAX = '1;
   localparam int unsigned          SPK_OUT_BIT = 5;

   initial begin
      assert (IRQ_CNT_W >= 2) else $error("IRQ_CNT_W too small");
      assert (GATED_CH < NUM_CH) else $error("GATED_CH out of range");
      assert (!(CTRL_PORT >= DATA_BASE && CTRL_PORT < DATA_BASE + NUM_CH))
         else $error("control port overlaps data ports");
      assert (!(SPKR_PORT >= DATA_BASE && SPKR_PORT < DATA_BASE + NUM_CH))
         else $error("speaker port overlaps data ports");
      assert (CTRL_PORT != SPKR_PORT) else $error("port clash");
   end

   logic [ADDR_W-1:0] offs;
   logic [1:0]        sel;
   logic              is_data, is_ctrl, is_spk, hit;
   logic              data_wr, data_rd, ctrl_wr, spk_wr;
   logic [NUM_CH-1:0] cfg_we, latch_req, wr_en, rd_en, ch_out, ch_evt, ch_gate;
   logic [BYTE_W-1:0] ch_rd [NUM_CH];
   logic [BYTE_W-1:0] rd_mux;
   tmr_acc_e          cfg_acc;
   logic [2:0]        cfg_mode;
   logic              spk_gate;
   logic              unused_chan_bits;

   assign offs    = io_addr - BASE_A;
   assign is_data = (offs < ADDR_W'(NUM_CH));
   assign sel     = offs[1:0];
   assign is_ctrl = (io_addr == CTRL_A);
   assign is_spk  = (io_addr == SPKR_A);
   assign hit     = is_data || is_ctrl || is_spk;
   assign data_wr = io_valid &&  io_write && is_data;
   assign data_rd = io_valid && !io_write && is_data;
   assign ctrl_wr = io_valid &&  io_write && is_ctrl;
   assign spk_wr  = io_valid &&  io_write && is_spk;

   tmr_ctl_decode u_dec (
      .ctrl_wr   (ctrl_wr),
      .cw        (io_wdata),
      .cfg_we    (cfg_we),
      .latch_req (latch_req),
      .cfg_acc   (cfg_acc),
      .cfg_mode  (cfg_mode)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (i == GATED_CH) begin : g_gated
         assign ch_gate[i] = spk_gate;
      end else begin : g_free
         assign ch_gate[i] = 1'b1;
      end
      assign wr_en[i] = data_wr && (sel == 2'(i));
      assign rd_en[i] = data_rd && (sel == 2'(i));

      tmr_chan_ctr u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .gate      (ch_gate[i]),
         .cfg_we    (cfg_we[i]),
         .cfg_acc   (cfg_acc),
         .cfg_mode  (cfg_mode),
         .latch_req (latch_req[i]),
         .wr_en     (wr_en[i]),
         .wr_byte   (io_wdata),
         .rd_en     (rd_en[i]),
         .rd_byte   (ch_rd[i]),
         .out       (ch_out[i]),
         .evt       (ch_evt[i])
      );
   end

   assign unused_chan_bits = ^{ch_out, ch_evt};

   always_comb begin
      rd_mux = '0;
      if (is_data && sel < 2'(NUM_CH)) rd_mux = ch_rd[sel];
      else if (is_ctrl)                rd_mux = 8'hFF;
      else if (is_spk) begin
         rd_mux[0]           = spk_gate;
         rd_mux[SPK_OUT_BIT] = ch_out[GATED_CH];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rdata   <= '0;
         io_handled <= 1'b0;
         irq        <= 1'b0;
         irq_count  <= '0;
         spk_gate   <= 1'b0;
      end else begin
         io_handled <= io_valid && hit;
         io_rdata   <= (io_valid && !io_write) ? rd_mux : '0;
         if (spk_wr) spk_gate <= io_wdata[0];
         irq <= ch_evt[0];
         if (ch_evt[0] && irq_count != CNT_MAX) irq_count <= irq_count + 1'b1;
      end
   end

   // R1
   unknown_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && !hit) |=> (!io_handled && io_rdata == '0));

   // R10
   ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && !io_write && is_ctrl) |=> (io_handled && io_rdata == 8'hFF));

   // R9
   spk_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && !io_write && is_spk) |=> (io_rdata[7:6] == 2'b00 && io_rdata[4:1] == 4'h0));

   // R12
   irq_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_count == CNT_MAX) |=> (irq_count == CNT_MAX));

   // R11
   irq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_count != $past(irq_count)) |-> irq);
endmodule

// File: tb/tmr_port_if_tb.sv
`timescale 1ns/1ps
module tmr_port_if_tb;
   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic        io_valid = 1'b0, io_write = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata, irq_count;
   logic        io_handled, irq;

   int checks = 0, failures = 0, exp_cnt = 0, pulses = 0;
   logic [7:0] rd_s;
   logic       hd_s;

   always #5 clk = ~clk;

   tmr_port_if u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .io_valid(io_valid), .io_write(io_write),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .io_handled(io_handled), .irq(irq), .irq_count(irq_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic io(input logic [15:0] a, input logic w, input logic [7:0] d, input logic tk);
      @(negedge clk);
      io_valid = 1'b1; io_write = w; io_addr = a; io_wdata = d; tick = tk;
      @(negedge clk);
      io_valid = 1'b0; io_write = 1'b0; tick = 1'b0;
      rd_s = io_rdata; hd_s = io_handled;
   endtask

   task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
      io(a, 1'b1, d, 1'b0);
   endtask

   task automatic rd_port(input logic [15:0] a);
      io(a, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic run(input int n);
      pulses = 0;
      @(negedge clk); tick = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (irq) pulses++;
      end
      tick = 1'b0;
   endtask

   function automatic int sat(input int v);
      return (v > 255) ? 255 : v;
   endfunction

   task automatic rd_pair(input logic [15:0] a, input int exp16, input string req);
      rd_port(a); chk({req, " low byte"},  rd_s, exp16 & 8'hFF);
      rd_port(a); chk({req, " high byte"}, rd_s, (exp16 >> 8) & 8'hFF);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset irq", irq, 0);
      chk("R12 reset irq_count", irq_count, 0);
      chk("R1 reset handled", io_handled, 0);

      // R1 R10 R9: address sweep, reset speaker state 0x20 (gate low, out high)
      for (int a = 0; a < 128; a++) begin
         int eh, ed;
         rd_port(16'(a));
         eh = (a >= 'h40 && a <= 'h43) || a == 'h61;
         ed = (a == 'h43) ? 'hFF : (a == 'h61) ? 'h20 : 0;
         chk($sformatf("R1 handled addr 0x%0h", a), hd_s, eh);
         chk($sformatf("R1/R10/R9 rdata addr 0x%0h", a), rd_s, ed);
      end
      rd_port(16'h0140); chk("R1 upper bits 0x140", hd_s, 0);
      rd_port(16'h0161); chk("R1 upper bits 0x161", hd_s, 0);
      wr_port(16'h1043, 8'h34); chk("R1 write to unknown", hd_s, 0);

      // R2 R4: 0x34, 0x00, 0x04 gives reload 0x0400
      wr_port(16'h43, 8'h34); chk("R1 ctrl write handled", hd_s, 1);
      wr_port(16'h40, 8'h00); wr_port(16'h40, 8'h04);
      wr_port(16'h43, 8'h00);
      rd_pair(16'h40, 'h0400, "R2/R4/R6 reload 0x0400");

      // R8 R11: mode 2 reload 3, event every 4 ticks
      wr_port(16'h43, 8'h34); wr_port(16'h40, 8'h03); wr_port(16'h40, 8'h00);
      run(20); exp_cnt += 5;
      chk("R11 ch0 mode2 pulses", pulses, 5);
      chk("R12 count after mode2", irq_count, sat(exp_cnt));
      rd_pair(16'h40, 'h0003, "R5/R8 count after reload");

      // R3 R11: reconfigure ch0 stops it; ch1 events give no irq
      wr_port(16'h43, 8'h34);
      wr_port(16'h43, 8'h74); wr_port(16'h41, 8'h02); wr_port(16'h41, 8'h00);
      run(30);
      chk("R11 ch1 events no pulse", pulses, 0);
      chk("R11 ch1 events no count", irq_count, sat(exp_cnt));
      rd_pair(16'h40, 'h0003, "R3 stopped ch0 holds");
      rd_pair(16'h41, 'h0002, "R8 ch1 mode2 wrap");

      // R8: mode 0 single event then stop
      wr_port(16'h43, 8'h30); wr_port(16'h40, 8'h05); wr_port(16'h40, 8'h00);
      run(10); exp_cnt += 1;
      chk("R8 mode0 one pulse", pulses, 1);
      rd_pair(16'h40, 'h0000, "R8 mode0 halts at 0");
      // R2: mode code 7 acts as mode 0
      wr_port(16'h43, 8'h3E); wr_port(16'h40, 8'h02); wr_port(16'h40, 8'h00);
      run(8); exp_cnt += 1;
      chk("R2 mode7 as mode0 pulses", pulses, 1);
      chk("R12 count", irq_count, sat(exp_cnt));

      // R9: ch2 gated off after reset, then square wave via speaker gate
      wr_port(16'h43, 8'hB6); wr_port(16'h42, 8'h02); wr_port(16'h42, 8'h00);
      run(3);
      rd_port(16'h61); chk("R9 ch2 gate low at reset", rd_s, 'h20);
      wr_port(16'h61, 8'h01);
      rd_port(16'h61); chk("R9 gate on, out high", rd_s, 'h21);
      run(3);
      rd_port(16'h61); chk("R8/R9 square toggles low", rd_s, 'h01);
      chk("R11 ch2 no pulse", pulses, 0);
      run(3);
      rd_port(16'h61); chk("R8/R9 square toggles high", rd_s, 'h21);
      wr_port(16'h61, 8'h00);
      run(9);
      rd_port(16'h61); chk("R9 gate off holds output", rd_s, 'h20);

      // R7: read-back latches
      wr_port(16'h43, 8'h34); wr_port(16'h40, 8'h34); wr_port(16'h40, 8'h12);
      wr_port(16'h43, 8'h74); wr_port(16'h41, 8'h50); wr_port(16'h41, 8'h00);
      run(16);
      wr_port(16'h43, 8'hD6);
      run(5);
      rd_pair(16'h40, 'h1224, "R7 readback ch0");
      rd_pair(16'h41, 'h0040, "R7 readback ch1");
      wr_port(16'h43, 8'hFE);
      run(4);
      rd_pair(16'h40, 'h121B, "R7 both bits set no latch");
      wr_port(16'h43, 8'hE2);
      run(3);
      rd_pair(16'h40, 'h121B, "R7 status request latches");

      // R6: second latch ignored while pending
      wr_port(16'h43, 8'h00);
      run(2);
      wr_port(16'h43, 8'h00);
      run(2);
      rd_pair(16'h40, 'h1218, "R6 first latch kept");
      rd_pair(16'h40, 'h1214, "R6 live after readout");

      // R13: load with tick, read with tick
      wr_port(16'h43, 8'h54);
      io(16'h41, 1'b1, 8'h07, 1'b1);
      rd_port(16'h41); chk("R13 load wins over tick", rd_s, 'h07);
      io(16'h41, 1'b0, 8'h00, 1'b1); chk("R13 read returns pre-tick", rd_s, 'h07);
      rd_port(16'h41); chk("R13 tick applied after read", rd_s, 'h06);
      io(16'h43, 1'b1, 8'h54, 1'b1);
      rd_port(16'h41); chk("R13/R3 config drops tick", rd_s, 'h06);

      // R4 R5: high-only load of 0 gives 0xFFFF
      wr_port(16'h43, 8'h64); wr_port(16'h41, 8'h00);
      rd_port(16'h41); chk("R4/R5 high-only read", rd_s, 'hFF);
      wr_port(16'h43, 8'h54);
      rd_port(16'h41); chk("R4/R5 zero load low byte", rd_s, 'hFF);

      // R12: saturation with reload 1 (event every 2 ticks)
      wr_port(16'h43, 8'h34); wr_port(16'h40, 8'h01); wr_port(16'h40, 8'h00);
      run(600); exp_cnt += 300;
      chk("R11 pulses reload 1", pulses, 300);
      chk("R12 saturated", irq_count, sat(exp_cnt));
      run(10);
      chk("R11 pulses after saturation", pulses, 5);
      chk("R12 stays saturated", irq_count, 255);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule